// File: doc/BRIEF.md
# Pixel Word Unpacker

This block turns a stream of 32-bit memory words, taken from a show-ahead FIFO, into one 24-bit colour pixel per request from a display sequencer. Each granted request produces 8-bit red, green and blue values on the next clock. The block removes words from the FIFO only as the selected pixel format needs them.

A static format input selects one of three layouts. The first is 5-6-5 colour with two pixels per word, where each channel is widened to 8 bits. The second is 24-bit colour with one pixel per word and a spare top byte. The third is 24-bit colour packed with no gaps, so four pixels span three words. In the packed layout a pixel can straddle two words. The block keeps the previous word in a holding register and steps through a four-phase sequence to pick the right bytes. A synchronous frame-start input returns the sequence to its first phase. When a word is needed and the FIFO is empty, the request is refused for that cycle and an underflow flag is raised instead.

Top module: `pixel_unpacker`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `pix_valid_o`, `underflow_o` and `fifo_pop_o` are all low.
- R2: With `mode_i` = 0 (5-6-5), each word yields two pixels, bits 15:0 first and then bits 31:16. `fifo_pop_o` is asserted only for the first pixel of each word, so N pixels consume N/2 words.
- R3: A 5-6-5 half-word holds red in bits 15:11, green in 10:5 and blue in 4:0. Each channel is widened to 8 bits by repeating its own bits from the most significant downward: red = {r, r[4:2]}, green = {g, g[5:4]}, blue = {b, b[4:2]}.
- R4: With `mode_i` = 1 (sparse 24-bit), every pixel pops one word. Red = bits 23:16, green = 15:8 and blue = 7:0. Bits 31:24 have no effect on the output.
- R5: With `mode_i` = 2 or 3 (dense 24-bit), byte k of the stream is bits 8(k%4)+7:8(k%4) of word k/4. Pixel n has blue = byte 3n, green = byte 3n+1 and red = byte 3n+2. Pops occur on pixels 0, 1 and 2 of every group of four and not on pixel 3, so N pixels consume ceil(3N/4) words.
- R6: A granted request gives `pix_valid_o` high with the pixel on the red, green and blue outputs in the following cycle. A cycle without a request gives `pix_valid_o` low in the following cycle.
- R7: If a request needs a word and `fifo_empty_i` is high, there is no pop. In the following cycle `pix_valid_o` is low and `underflow_o` is high. The format phase is unchanged, so a retry returns the same pixel that was refused.
- R8: `fifo_pop_o` is never asserted while `fifo_empty_i` is high. A request that needs no word (the second 5-6-5 pixel, or dense pixel 3) is granted even when the FIFO is empty.
- R9: `frame_start_i` high returns the phase to the first pixel of a word and clears the held word. A request in the same cycle is ignored: there is no pop, and in the next cycle both `pix_valid_o` and `underflow_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Pixel format: 0 = 5-6-5, 1 = sparse 24-bit, 2 or 3 = dense 24-bit |
| frame_start_i | input | 1 | Synchronous restart of the phase sequence |
| pix_req_i | input | 1 | Sequencer asks for one pixel |
| fifo_word_i | input | 32 | Head word of the show-ahead FIFO |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_pop_o | output | 1 | Remove the head word at this clock edge |
| pix_valid_o | output | 1 | Pixel outputs carry a new pixel |
| red_o | output | 8 | Red channel |
| green_o | output | 8 | Green channel |
| blue_o | output | 8 | Blue channel |
| underflow_o | output | 1 | Previous request was refused because the FIFO was empty |

## Verification
The 5-6-5 path is swept over all 65536 half-word values, using words whose halves count upward. This separates bit-field and widening errors from half-order errors. The sparse and dense paths run on byte streams built from several linear formulas, so a wrong byte lane, a swapped channel or a missed holding byte shows up as a mismatch, and a wrong pop rhythm shows up as a wrong word count. The FIFO is throttled so that it runs dry on a straddling pixel, on a pixel that needs no pop, and on the first pixel of a group, and a frame restart is issued in the middle of a dense group. These cases distinguish correct stall and restart handling from handling that drifts the phase or drops a byte.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  typedef enum logic [1:0] {
    FMT_565    = 2'd0,
    FMT_SPARSE = 2'd1,
    FMT_DENSE  = 2'd2
  } pix_fmt_e;

  localparam int DENSE_PHASES = 4;
  localparam int PH_W         = $clog2(DENSE_PHASES);

  localparam int R565_BITS = 5;
  localparam int G565_BITS = 6;
  localparam int B565_BITS = 5;

  function automatic pix_fmt_e decode_fmt(input logic [1:0] code);
    pix_fmt_e f;
    case (code)
      2'd0:    f = FMT_565;
      2'd1:    f = FMT_SPARSE;
      default: f = FMT_DENSE;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/pxu_rst_sync.sv
module pxu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/pxu_phase_ctrl.sv
module pxu_phase_ctrl
  import pxu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  pix_fmt_e        fmt_i,
  input  logic            req_i,
  input  logic            frame_start_i,
  input  logic            fifo_empty_i,
  output logic [PH_W-1:0] phase_o,
  output logic            pop_o,
  output logic            accept_o,
  output logic            starve_o
);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_nxt;
  logic            need_word;
  logic            live_req;
  logic            phase_en;

  // Which phases must fetch a fresh word
  always_comb begin
    case (fmt_i)
      FMT_565:    need_word = (phase_q == '0);
      FMT_SPARSE: need_word = 1'b1;
      default:    need_word = (phase_q != PH_W'(DENSE_PHASES - 1));
    endcase
  end

  assign live_req = req_i && !frame_start_i;
  assign starve_o = live_req && need_word && fifo_empty_i;
  assign accept_o = live_req && !(need_word && fifo_empty_i);
  assign pop_o    = accept_o && need_word;

  always_comb begin
    phase_nxt = phase_q;
    if (frame_start_i) begin
      phase_nxt = '0;
    end else if (accept_o) begin
      case (fmt_i)
        FMT_565:    phase_nxt = (phase_q == '0) ? PH_W'(1) : '0;
        FMT_SPARSE: phase_nxt = '0;
        default:    phase_nxt = (phase_q == PH_W'(DENSE_PHASES - 1)) ? '0 : phase_q + PH_W'(1);
      endcase
    end
  end

  assign phase_en = frame_start_i || accept_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_nxt;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/pxu_byte_select.sv
module pxu_byte_select
  import pxu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CH_W   = 8
) (
  input  pix_fmt_e          fmt_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic [WORD_W-1:0] cur_word_i,
  input  logic [WORD_W-1:0] held_word_i,
  output logic [3*CH_W-1:0] px24_o,
  output logic [WORD_W/2-1:0] half_o
);

  localparam int BYTES  = WORD_W / CH_W;
  localparam int PIX_W  = 3 * CH_W;
  localparam int HALF_W = WORD_W / 2;

  logic [2*WORD_W-1:0] joined;
  logic [PIX_W-1:0]    dense_cand [DENSE_PHASES];
  logic [PIX_W-1:0]    dense_px;
  logic                unused_bits;

  // held word in the low half, fresh word above: byte windows slide down
  assign joined = {cur_word_i, held_word_i};

  genvar ph;
  generate
    for (ph = 0; ph < DENSE_PHASES; ph++) begin : g_window
      assign dense_cand[ph] = joined[CH_W*(BYTES-ph) +: PIX_W];
    end
  endgenerate

  assign dense_px = dense_cand[phase_i];

  always_comb begin
    case (fmt_i)
      FMT_SPARSE: px24_o = cur_word_i[PIX_W-1:0];
      default:    px24_o = dense_px;
    endcase
  end

  assign half_o = (phase_i[0] == 1'b0) ? cur_word_i[HALF_W-1:0]
                                       : held_word_i[WORD_W-1:HALF_W];

  assign unused_bits = ^{cur_word_i[WORD_W-1:PIX_W], held_word_i[CH_W-1:0]};

endmodule

// File: rtl/pxu_colour_expand.sv
module pxu_colour_expand
  import pxu_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  pix_fmt_e          fmt_i,
  input  logic [15:0]       half_i,
  input  logic [3*CH_W-1:0] px24_i,
  output logic [CH_W-1:0]   red_o,
  output logic [CH_W-1:0]   green_o,
  output logic [CH_W-1:0]   blue_o
);

  localparam int G_LO = B565_BITS;
  localparam int R_LO = B565_BITS + G565_BITS;

  // Fill a channel by cycling its bits from the top; v is left-aligned
  function automatic logic [CH_W-1:0] widen(input logic [CH_W-1:0] v, input int bits);
    logic [CH_W-1:0] w;
    for (int i = 0; i < CH_W; i++) begin
      w[CH_W-1-i] = v[CH_W-1-(i % bits)];
    end
    return w;
  endfunction

  logic [CH_W-1:0] r_wide;
  logic [CH_W-1:0] g_wide;
  logic [CH_W-1:0] b_wide;

  assign r_wide = widen({half_i[R_LO +: R565_BITS], {(CH_W-R565_BITS){1'b0}}}, R565_BITS);
  assign g_wide = widen({half_i[G_LO +: G565_BITS], {(CH_W-G565_BITS){1'b0}}}, G565_BITS);
  assign b_wide = widen({half_i[0 +: B565_BITS],    {(CH_W-B565_BITS){1'b0}}}, B565_BITS);

  always_comb begin
    if (fmt_i == FMT_565) begin
      red_o   = r_wide;
      green_o = g_wide;
      blue_o  = b_wide;
    end else begin
      red_o   = px24_i[2*CH_W +: CH_W];
      green_o = px24_i[CH_W +: CH_W];
      blue_o  = px24_i[0 +: CH_W];
    end
  end

endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import pxu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CH_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              frame_start_i,
  input  logic              pix_req_i,
  input  logic [WORD_W-1:0] fifo_word_i,
  input  logic              fifo_empty_i,
  output logic              fifo_pop_o,
  output logic              pix_valid_o,
  output logic [CH_W-1:0]   red_o,
  output logic [CH_W-1:0]   green_o,
  output logic [CH_W-1:0]   blue_o,
  output logic              underflow_o
);

  logic              rst_n_s;
  pix_fmt_e          fmt;
  logic [PH_W-1:0]   phase;
  logic              pop;
  logic              accept;
  logic              starve;
  logic [WORD_W-1:0] held_q;
  logic [WORD_W-1:0] held_nxt;
  logic              held_en;
  logic [3*CH_W-1:0] px24;
  logic [WORD_W/2-1:0] half;
  logic [CH_W-1:0]   r_c, g_c, b_c;
  logic [CH_W-1:0]   r_q, g_q, b_q;
  logic              valid_q, under_q;

  assign fmt = decode_fmt(mode_i);

  pxu_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  pxu_phase_ctrl u_phase (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .fmt_i         (fmt),
    .req_i         (pix_req_i),
    .frame_start_i (frame_start_i),
    .fifo_empty_i  (fifo_empty_i),
    .phase_o       (phase),
    .pop_o         (pop),
    .accept_o      (accept),
    .starve_o      (starve)
  );

  pxu_byte_select #(.WORD_W(WORD_W), .CH_W(CH_W)) u_sel (
    .fmt_i       (fmt),
    .phase_i     (phase),
    .cur_word_i  (fifo_word_i),
    .held_word_i (held_q),
    .px24_o      (px24),
    .half_o      (half)
  );

  pxu_colour_expand #(.CH_W(CH_W)) u_exp (
    .fmt_i   (fmt),
    .half_i  (half),
    .px24_i  (px24),
    .red_o   (r_c),
    .green_o (g_c),
    .blue_o  (b_c)
  );

  // Holding register keeps the last popped word for straddling pixels
  assign held_en  = frame_start_i || pop;
  assign held_nxt = frame_start_i ? '0 : fifo_word_i;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     held_q <= '0;
    else if (held_en) held_q <= held_nxt;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      r_q <= '0;
      g_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      r_q <= r_c;
      g_q <= g_c;
      b_q <= b_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      valid_q <= 1'b0;
      under_q <= 1'b0;
    end else begin
      valid_q <= accept;
      under_q <= starve;
    end
  end

  assign fifo_pop_o  = pop;
  assign pix_valid_o = valid_q;
  assign underflow_o = under_q;
  assign red_o       = r_q;
  assign green_o     = g_q;
  assign blue_o      = b_q;

endmodule

// File: rtl/pxu_checker.sv
module pxu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       frame_start_i,
  input logic       pix_req_i,
  input logic       fifo_empty_i,
  input logic       fifo_pop_o,
  input logic       pix_valid_o,
  input logic       underflow_o
);

  // R8
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> !fifo_empty_i);

  // R6
  valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> ($past(pix_req_i) && !$past(frame_start_i)));

  // R7
  underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> (!pix_valid_o && $past(fifo_empty_i) && !$past(fifo_pop_o)));

  // R9
  frame_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |-> !fifo_pop_o);

  // R9
  frame_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (!pix_valid_o && !underflow_o));

  // R4
  sparse_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && pix_req_i && !frame_start_i && !fifo_empty_i) |-> fifo_pop_o);

  // R2
  half_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 && fifo_pop_o) |=> (mode_i != 2'd0 || !fifo_pop_o));

endmodule

bind pixel_unpacker pxu_checker u_pxu_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_i        (mode_i),
  .frame_start_i (frame_start_i),
  .pix_req_i     (pix_req_i),
  .fifo_empty_i  (fifo_empty_i),
  .fifo_pop_o    (fifo_pop_o),
  .pix_valid_o   (pix_valid_o),
  .underflow_o   (underflow_o)
);

// File: tb/pixel_unpacker_test.sv
`timescale 1ns/1ps
module pixel_unpacker_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        fs;
  logic        req;
  logic [31:0] fifo_word;
  logic        fifo_empty;
  logic        pop;
  logic        valid;
  logic [7:0]  red, green, blue;
  logic        under;

  int  n_chk = 0;
  int  n_err = 0;
  int  rd;
  int  lim;
  bit  rd_clr;
  bit  exh;
  int  mul, add;
  int  pos, ph;
  logic pop_seen;
  int  cycles = 0;

  always #2 clk = ~clk;

  function automatic logic [31:0] wgen(input int i, input bit e, input int m, input int a);
    logic [31:0] w;
    if (e) begin
      w = {16'(2*i+1), 16'(2*i)};
    end else begin
      for (int j = 0; j < 4; j++) w[8*j +: 8] = 8'((4*i+j)*m + a);
    end
    return w;
  endfunction

  assign fifo_word  = wgen(rd, exh, mul, add);
  assign fifo_empty = (rd >= lim);

  always @(posedge clk) begin
    if (rd_clr)   rd <= 0;
    else if (pop) rd <= rd + 1;
  end

  pixel_unpacker uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .frame_start_i(fs),
    .pix_req_i(req), .fifo_word_i(fifo_word), .fifo_empty_i(fifo_empty),
    .fifo_pop_o(pop), .pix_valid_o(valid), .red_o(red), .green_o(green),
    .blue_o(blue), .underflow_o(under)
  );

  function automatic logic [7:0] byte_at(input int n);
    logic [31:0] w;
    w = wgen(n / 4, exh, mul, add);
    return w[8*(n%4) +: 8];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic r, input logic f);
    req = r;
    fs  = f;
    #1;
    pop_seen = pop;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart(input logic [1:0] m, input bit e, input int mu, input int ad);
    mode = m; exh = e; mul = mu; add = ad;
    rd_clr = 1'b1;
    step(1'b0, 1'b1);
    rd_clr = 1'b0;
    pos = 0;
    ph  = 0;
  endtask

  task automatic px(input string tag);
    logic [7:0]  er, eg, eb;
    logic [15:0] h;
    logic        ep;
    if (mode == 2'd0) begin
      h  = {byte_at(2*pos+1), byte_at(2*pos)};
      er = {h[15:11], h[15:13]};
      eg = {h[10:5], h[10:9]};
      eb = {h[4:0], h[4:2]};
      ep = (ph == 0);
      pos++; ph = (ph == 0) ? 1 : 0;
    end else if (mode == 2'd1) begin
      eb = byte_at(4*pos); eg = byte_at(4*pos+1); er = byte_at(4*pos+2);
      ep = 1'b1;
      pos++;
    end else begin
      eb = byte_at(pos); eg = byte_at(pos+1); er = byte_at(pos+2);
      ep = (ph != 3);
      pos += 3; ph = (ph + 1) % 4;
    end
    step(1'b1, 1'b0);
    chk(pop_seen == ep, {tag, " pop"}, 32'(pop_seen), 32'(ep));
    chk(valid === 1'b1 && {red, green, blue} === {er, eg, eb}, {tag, " pixel"},
        {7'd0, valid, red, green, blue}, {8'd1, er, eg, eb});
  endtask

  task automatic refused(input string tag);
    step(1'b1, 1'b0);
    chk(!pop_seen, {tag, " no pop"}, 32'(pop_seen), 32'd0);
    chk(!valid && under, {tag, " flags"}, {30'd0, valid, under}, 32'd1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_err++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; fs = 1'b0; req = 1'b0; rd_clr = 1'b1;
    exh = 1'b0; mul = 1; add = 0; lim = 1 << 30; pos = 0; ph = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!valid && !under && !pop, "R1 in reset", {29'd0, valid, under, pop}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
    chk(!valid && !under && !pop, "R1 after reset", {29'd0, valid, under, pop}, 32'd0);
    repeat (3) @(negedge clk);

    // R2 R3 exhaustive 5-6-5 sweep
    restart(2'd0, 1'b1, 0, 0);
    for (int k = 0; k < 65536; k++) px("R3 565 sweep");
    chk(rd == 32768, "R2 word count", 32'(rd), 32'd32768);

    // R6 idle cycle gives no valid
    step(1'b0, 1'b0);
    chk(!valid, "R6 idle", 32'(valid), 32'd0);

    // R4 sparse format, several streams
    for (int s = 0; s < 3; s++) begin
      restart(2'd1, 1'b0, 13 + 44*s, 7 + 91*s);
      for (int k = 0; k < 20; k++) px("R4 sparse");
      chk(rd == 20, "R4 word count", 32'(rd), 32'd20);
    end

    // R5 dense format, codes 2 and 3
    for (int s = 0; s < 4; s++) begin
      restart((s % 2 == 0) ? 2'd2 : 2'd3, 1'b0, 29 + 38*s, 3 + 57*s);
      for (int k = 0; k < 24; k++) px("R5 dense");
      chk(rd == 18, "R5 word count", 32'(rd), 32'd18);
    end

    // R7 R8 dense stalls
    restart(2'd2, 1'b0, 71, 5);
    lim = 1;
    px("R7 dense p0");
    refused("R7 dense straddle");
    refused("R7 dense repeat");
    lim = 3;
    px("R7 dense retry p1");
    px("R7 dense p2");
    px("R8 dense p3 empty fifo");
    refused("R7 dense group start");
    lim = 1 << 30;
    px("R7 dense resume");
    px("R7 dense resume2");

    // R8 5-6-5 second half with empty FIFO
    restart(2'd0, 1'b0, 19, 200);
    lim = 1;
    px("R8 565 first");
    px("R8 565 second empty fifo");
    refused("R7 565 next word");
    lim = 1 << 30;
    px("R7 565 resume");

    // R9 restart in mid group
    restart(2'd2, 1'b0, 53, 17);
    px("R9 pre p0");
    px("R9 pre p1");
    step(1'b1, 1'b1);
    chk(!pop_seen, "R9 no pop", 32'(pop_seen), 32'd0);
    chk(!valid && !under, "R9 quiet", {30'd0, valid, under}, 32'd0);
    pos = 4 * rd;
    ph  = 0;
    for (int k = 0; k < 8; k++) px("R9 post");

    step(1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule